// File: doc/BRIEF.md
# Operand-Wakeup Reservation Pool

This block keeps a small set of operations for one class of execution unit while they wait for their source operands. An issue stage writes an operation into a free slot. Each source is written either as a value or as the tag of the reorder-buffer entry that will produce it. An immediate constant goes straight into the second value slot. Each operation also carries the reorder-buffer tag of its own result.

Every cycle, each waiting slot compares its pending tags against two result buses. A match copies the bus value in and clears the wait. Once a slot has no pending source it is eligible. The oldest eligible slot is presented on the dispatch port and is freed at the next edge. A free-slot count and a full flag tell the issue stage whether it may write. A flush input empties the whole pool in one cycle.

Top module: `rs_pool`

## Requirements
- R1: After reset, no slot is occupied: `free_cnt` equals ENTRIES, `pool_full` is 0 and `disp_valid` is 0.
- R2: An operation issued with both sources marked not pending appears on the dispatch port in the cycle after issue, carrying its op code, destination tag and both values. An immediate is given as the second source with its pending bit at 0.
- R3: A pending source captures the value of whichever bus (0 or 1) is valid with a matching tag. The slot dispatches in the cycle after the last capture.
- R4: Both buses can wake sources of the same slot in the same cycle, with either bus feeding either source.
- R5: A source issued as pending whose tag matches a valid bus in the issue cycle stores the bus value and is not left waiting.
- R6: At most one slot dispatches per cycle. Among eligible slots the one issued earliest wins, whatever its slot index.
- R7: A dispatched slot is freed at the edge that ends its dispatch cycle, and `free_cnt` rises by one.
- R8: `flush` empties every slot in one cycle. Bus results that arrive later wake nothing and dispatch nothing.
- R9: `free_cnt` counts the empty slots, and `pool_full` is 1 exactly when that count is 0.
- R10: A bus that is not valid, or that carries a tag different from a pending one, leaves the slot waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty every slot |
| iss_valid | input | 1 | Write an operation into a free slot |
| iss_op | input | 4 | Operation code |
| iss_dst | input | 4 | Reorder-buffer tag of the result |
| iss_j_pend | input | 1 | First source still being produced |
| iss_j_tag | input | 4 | Producer tag of first source |
| iss_j_val | input | 32 | Value of first source |
| iss_k_pend | input | 1 | Second source still being produced |
| iss_k_tag | input | 4 | Producer tag of second source |
| iss_k_val | input | 32 | Value of second source or immediate |
| cdb0_valid | input | 1 | Result bus 0 valid |
| cdb0_tag | input | 4 | Result bus 0 tag |
| cdb0_value | input | 32 | Result bus 0 value |
| cdb1_valid | input | 1 | Result bus 1 valid |
| cdb1_tag | input | 4 | Result bus 1 tag |
| cdb1_value | input | 32 | Result bus 1 value |
| disp_valid | output | 1 | An operation is sent to the unit this cycle |
| disp_op | output | 4 | Dispatched op code |
| disp_dst | output | 4 | Dispatched destination tag |
| disp_vj | output | 32 | Dispatched first value |
| disp_vk | output | 32 | Dispatched second value |
| free_cnt | output | 2 | Number of empty slots |
| pool_full | output | 1 | No empty slot |

## Verification
The assertions rely on the issue stage asserting `iss_valid` only while `pool_full` is low. They also rely on the two buses never carrying the same tag in one cycle. The bench keeps to both rules: each scenario issues only into a pool with room, and it drives distinct tags whenever both buses are active. The execution unit is taken to accept every dispatch, so the bench samples the dispatch port in every cycle in which a slot can become eligible.

// File: rtl/rs_pool_pkg.sv
// Shared widths, bus and source-operand types for the reservation pool.
// Assumes one reorder-buffer tag space shared by both result buses.
package rs_pool_pkg;
    localparam int unsigned RS_DATA_W = 32;
    localparam int unsigned RS_TAG_W  = 4;
    localparam int unsigned RS_OP_W   = 4;

    typedef struct packed {
        logic                 valid;
        logic [RS_TAG_W-1:0]  tag;
        logic [RS_DATA_W-1:0] value;
    } rs_bus_t;

    typedef struct packed {
        logic                 pend;
        logic [RS_TAG_W-1:0]  tag;
        logic [RS_DATA_W-1:0] value;
    } rs_src_t;

    // Return the source updated by whichever bus matches its pending tag.
    function automatic rs_src_t rs_snoop(rs_src_t s, rs_bus_t b0, rs_bus_t b1);
        rs_src_t r;
        r = s;
        if (s.pend && b0.valid && (b0.tag == s.tag)) begin
            r.pend  = 1'b0;
            r.value = b0.value;
        end else if (s.pend && b1.valid && (b1.tag == s.tag)) begin
            r.pend  = 1'b0;
            r.value = b1.value;
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_slot.sv
// One pool slot: holds an operation and its two sources, and wakes each
// pending source from either result bus. Assumes wr_en only while empty
// and clr only while eligible. Flush overrides write and clear.
module rs_slot
    import rs_pool_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                wr_en,
    input  logic [RS_OP_W-1:0]  wr_op,
    input  logic [RS_TAG_W-1:0] wr_dst,
    input  rs_src_t             wr_j,
    input  rs_src_t             wr_k,
    input  rs_bus_t             bus0,
    input  rs_bus_t             bus1,
    input  logic                clr,
    output logic                busy,
    output logic                eligible,
    output logic [RS_OP_W-1:0]  op,
    output logic [RS_TAG_W-1:0] dst,
    output rs_src_t             src_j,
    output rs_src_t             src_k
);
    logic                busy_q;
    logic [RS_OP_W-1:0]  op_q;
    logic [RS_TAG_W-1:0] dst_q;
    rs_src_t             j_q, k_q;

    // Slot state: load on issue (with same-cycle capture), wake on bus, free on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            op_q   <= '0;
            dst_q  <= '0;
            j_q    <= '0;
            k_q    <= '0;
        end else if (flush) begin
            busy_q <= 1'b0;
        end else if (wr_en) begin
            busy_q <= 1'b1;
            op_q   <= wr_op;
            dst_q  <= wr_dst;
            j_q    <= rs_snoop(wr_j, bus0, bus1);
            k_q    <= rs_snoop(wr_k, bus0, bus1);
        end else begin
            if (clr) busy_q <= 1'b0;
            j_q <= rs_snoop(j_q, bus0, bus1);
            k_q <= rs_snoop(k_q, bus0, bus1);
        end
    end

    assign busy     = busy_q;
    assign eligible = busy_q && !j_q.pend && !k_q.pend;
    assign op       = op_q;
    assign dst      = dst_q;
    assign src_j    = j_q;
    assign src_k    = k_q;

    // A pending first source matching bus 0 holds that value next cycle.
    p_wake_bus0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !flush && !wr_en && j_q.pend && bus0.valid && bus0.tag == j_q.tag
        |=> !j_q.pend && j_q.value == $past(bus0.value));

    // Flush leaves the slot empty.
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !busy_q);

    // A cleared slot is empty next cycle.
    p_free_after_disp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !flush && !wr_en |=> !busy_q);

    // Only a full, non-waiting slot is cleared by the picker.
    p_clear_only_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> busy_q && !j_q.pend && !k_q.pend);
endmodule

// File: rtl/rs_age_pick.sv
// Age-matrix picker: remembers issue order of slots and grants the
// oldest requesting slot. Assumes alloc_idx names an empty slot.
module rs_age_pick #(
    parameter int unsigned N     = 3,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);
    // older_q[a][b] set: slot a was written before slot b.
    logic [N-1:0] older_q [N];

    // Order update: a newly written slot is younger than every other slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < N; a++) older_q[a] <= '0;
        end else if (alloc_en) begin
            for (int a = 0; a < N; a++) begin
                if (a == int'(alloc_idx)) older_q[a] <= '0;
                else                      older_q[a][alloc_idx] <= 1'b1;
            end
        end
    end

    // Grant: a requester with no older requester.
    always_comb begin
        for (int b = 0; b < N; b++) begin
            gnt[b] = req[b];
            for (int a = 0; a < N; a++)
                if (a != b && req[a] && older_q[a][b]) gnt[b] = 1'b0;
        end
    end

    // Encode the grant.
    always_comb begin
        gnt_idx = '0;
        for (int b = 0; b < N; b++)
            if (gnt[b]) gnt_idx = IDX_W'(b);
    end

    assign gnt_valid = |gnt;

    // Never more than one slot dispatched per cycle.
    p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // Some request always wins when any is raised.
    p_grant_when_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> gnt_valid);
endmodule

// File: rtl/rs_pool.sv
// Reservation pool top: writes issued operations into the lowest empty
// slot, lets each slot snoop two result buses, and dispatches the oldest
// eligible slot. Assumes issue only when not full, and distinct tags on
// the two buses in any one cycle. The unit accepts every dispatch.
module rs_pool
    import rs_pool_pkg::*;
#(
    parameter int unsigned ENTRIES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 iss_valid,
    input  logic [RS_OP_W-1:0]   iss_op,
    input  logic [RS_TAG_W-1:0]  iss_dst,
    input  logic                 iss_j_pend,
    input  logic [RS_TAG_W-1:0]  iss_j_tag,
    input  logic [RS_DATA_W-1:0] iss_j_val,
    input  logic                 iss_k_pend,
    input  logic [RS_TAG_W-1:0]  iss_k_tag,
    input  logic [RS_DATA_W-1:0] iss_k_val,
    input  logic                 cdb0_valid,
    input  logic [RS_TAG_W-1:0]  cdb0_tag,
    input  logic [RS_DATA_W-1:0] cdb0_value,
    input  logic                 cdb1_valid,
    input  logic [RS_TAG_W-1:0]  cdb1_tag,
    input  logic [RS_DATA_W-1:0] cdb1_value,
    output logic                 disp_valid,
    output logic [RS_OP_W-1:0]   disp_op,
    output logic [RS_TAG_W-1:0]  disp_dst,
    output logic [RS_DATA_W-1:0] disp_vj,
    output logic [RS_DATA_W-1:0] disp_vk,
    output logic [$clog2(ENTRIES+1)-1:0] free_cnt,
    output logic                 pool_full
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned CNT_W = $clog2(ENTRIES + 1);

    rs_bus_t bus0, bus1;
    rs_src_t new_j, new_k;
    assign bus0  = '{valid: cdb0_valid, tag: cdb0_tag, value: cdb0_value};
    assign bus1  = '{valid: cdb1_valid, tag: cdb1_tag, value: cdb1_value};
    assign new_j = '{pend: iss_j_pend, tag: iss_j_tag, value: iss_j_val};
    assign new_k = '{pend: iss_k_pend, tag: iss_k_tag, value: iss_k_val};

    logic [ENTRIES-1:0] busy, eligible, gnt;
    logic [RS_OP_W-1:0]  s_op  [ENTRIES];
    logic [RS_TAG_W-1:0] s_dst [ENTRIES];
    rs_src_t             s_j   [ENTRIES];
    rs_src_t             s_k   [ENTRIES];
    logic [IDX_W-1:0]    alloc_idx, gnt_idx;
    logic                alloc_en, gnt_valid;

    // Allocation: lowest empty slot, and count of empty slots.
    always_comb begin
        alloc_idx = '0;
        free_cnt  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!busy[i]) alloc_idx = IDX_W'(i);
            free_cnt = free_cnt + CNT_W'(!busy[i]);
        end
    end

    assign pool_full = (free_cnt == '0);
    assign alloc_en  = iss_valid && !pool_full && !flush;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        rs_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .wr_en    (alloc_en && (alloc_idx == IDX_W'(g))),
            .wr_op    (iss_op),
            .wr_dst   (iss_dst),
            .wr_j     (new_j),
            .wr_k     (new_k),
            .bus0     (bus0),
            .bus1     (bus1),
            .clr      (gnt[g]),
            .busy     (busy[g]),
            .eligible (eligible[g]),
            .op       (s_op[g]),
            .dst      (s_dst[g]),
            .src_j    (s_j[g]),
            .src_k    (s_k[g])
        );
    end

    rs_age_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_idx (alloc_idx),
        .req       (eligible),
        .gnt       (gnt),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    // Dispatch port driven from the granted slot.
    always_comb begin
        disp_valid = gnt_valid;
        disp_op    = s_op[gnt_idx];
        disp_dst   = s_dst[gnt_idx];
        disp_vj    = s_j[gnt_idx].value;
        disp_vk    = s_k[gnt_idx].value;
    end

    // Input rule: the issue stage only writes while room remains.
    p_issue_has_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !pool_full);

    // A written operation always reduces the empty count unless one leaves.
    p_count_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en && !gnt_valid |=> free_cnt == $past(free_cnt) - 1'b1);
endmodule

// File: tb/rs_pool_tb.sv
module rs_pool_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_op = '0, iss_dst = '0, iss_j_tag = '0, iss_k_tag = '0;
    logic        iss_j_pend = 1'b0, iss_k_pend = 1'b0;
    logic [31:0] iss_j_val = '0, iss_k_val = '0;
    logic        cdb0_valid = 1'b0, cdb1_valid = 1'b0;
    logic [3:0]  cdb0_tag = '0, cdb1_tag = '0;
    logic [31:0] cdb0_value = '0, cdb1_value = '0;
    logic        disp_valid, pool_full;
    logic [3:0]  disp_op, disp_dst;
    logic [31:0] disp_vj, disp_vk;
    logic [1:0]  free_cnt;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rs_pool u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_j_pend(iss_j_pend), .iss_j_tag(iss_j_tag), .iss_j_val(iss_j_val),
        .iss_k_pend(iss_k_pend), .iss_k_tag(iss_k_tag), .iss_k_val(iss_k_val),
        .cdb0_valid(cdb0_valid), .cdb0_tag(cdb0_tag), .cdb0_value(cdb0_value),
        .cdb1_valid(cdb1_valid), .cdb1_tag(cdb1_tag), .cdb1_value(cdb1_value),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_vj(disp_vj), .disp_vk(disp_vk),
        .free_cnt(free_cnt), .pool_full(pool_full)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one edge, then clear one-cycle pulses.
    task automatic step();
        @(posedge clk);
        #1;
        iss_valid = 1'b0; cdb0_valid = 1'b0; cdb1_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic issue(input logic [3:0] op, input logic [3:0] dst,
                         input logic jp, input logic [3:0] jt, input logic [31:0] jv,
                         input logic kp, input logic [3:0] kt, input logic [31:0] kv);
        iss_valid = 1'b1; iss_op = op; iss_dst = dst;
        iss_j_pend = jp; iss_j_tag = jt; iss_j_val = jv;
        iss_k_pend = kp; iss_k_tag = kt; iss_k_val = kv;
    endtask

    task automatic bus0(input logic [3:0] t, input logic [31:0] v);
        cdb0_valid = 1'b1; cdb0_tag = t; cdb0_value = v;
    endtask

    task automatic bus1(input logic [3:0] t, input logic [31:0] v);
        cdb1_valid = 1'b1; cdb1_tag = t; cdb1_value = v;
    endtask

    task automatic t_reset();
        chk("R1 free_cnt", free_cnt, 3);
        chk("R1 pool_full", pool_full, 0);
        chk("R1 disp_valid", disp_valid, 0);
    endtask

    task automatic t_ready_issue();
        issue(4'd5, 4'd2, 1'b0, 4'd0, 32'd100, 1'b0, 4'd0, 32'd8);
        step();
        chk("R2 disp_valid", disp_valid, 1);
        chk("R2 disp_op", disp_op, 5);
        chk("R2 disp_dst", disp_dst, 2);
        chk("R2 disp_vj", disp_vj, 100);
        chk("R2 disp_vk imm", disp_vk, 8);
        chk("R9 free_cnt busy", free_cnt, 2);
        step();
        chk("R7 freed disp_valid", disp_valid, 0);
        chk("R7 freed free_cnt", free_cnt, 3);
    endtask

    task automatic t_wake_one();
        issue(4'd1, 4'd3, 1'b1, 4'd1, 32'd0, 1'b0, 4'd0, 32'd1);
        step();
        chk("R3 waiting", disp_valid, 0);
        bus0(4'd7, 32'd99);
        cdb1_tag = 4'd1; cdb1_value = 32'd55; cdb1_valid = 1'b0;
        step();
        chk("R10 no wake", disp_valid, 0);
        chk("R10 still held", free_cnt, 2);
        bus1(4'd1, 32'd5);
        step();
        chk("R3 wake bus1", disp_valid, 1);
        chk("R3 vj", disp_vj, 5);
        chk("R3 vk", disp_vk, 1);
        chk("R3 dst", disp_dst, 3);
        step();
        chk("R7 empty", free_cnt, 3);
    endtask

    task automatic t_dual_wake();
        issue(4'd2, 4'd4, 1'b1, 4'd5, 32'd0, 1'b1, 4'd6, 32'd0);
        step();
        bus0(4'd6, 32'd66);
        bus1(4'd5, 32'd55);
        step();
        chk("R4 disp_valid", disp_valid, 1);
        chk("R4 vj from bus1", disp_vj, 55);
        chk("R4 vk from bus0", disp_vk, 66);
        step();
    endtask

    task automatic t_issue_capture();
        issue(4'd3, 4'd8, 1'b1, 4'd9, 32'd0, 1'b0, 4'd0, 32'd3);
        bus0(4'd9, 32'd77);
        step();
        chk("R5 disp_valid", disp_valid, 1);
        chk("R5 vj", disp_vj, 77);
        chk("R5 dst", disp_dst, 8);
        step();
    endtask

    task automatic t_fill_and_age();
        issue(4'd4, 4'd10, 1'b1, 4'd12, 32'd0, 1'b0, 4'd0, 32'd0);
        step();
        issue(4'd4, 4'd11, 1'b1, 4'd13, 32'd0, 1'b0, 4'd0, 32'd0);
        step();
        issue(4'd4, 4'd14, 1'b0, 4'd0, 32'd1, 1'b0, 4'd0, 32'd2);
        step();
        chk("R9 full count", free_cnt, 0);
        chk("R9 pool_full", pool_full, 1);
        chk("R6 only ready young", disp_dst, 14);
        bus0(4'd13, 32'd130);
        bus1(4'd12, 32'd120);
        step();
        chk("R9 not full", pool_full, 0);
        chk("R6 oldest first", disp_dst, 10);
        step();
        chk("R6 next oldest", disp_dst, 11);
        chk("R6 next value", disp_vj, 130);
        step();
        chk("R6 drained", disp_valid, 0);
    endtask

    task automatic t_age_index();
        issue(4'd6, 4'd1, 1'b0, 4'd0, 32'd1, 1'b0, 4'd0, 32'd1);
        step();
        chk("R2 first", disp_dst, 1);
        issue(4'd6, 4'd2, 1'b1, 4'd3, 32'd0, 1'b0, 4'd0, 32'd0);
        step();
        issue(4'd6, 4'd5, 1'b1, 4'd4, 32'd0, 1'b0, 4'd0, 32'd0);
        step();
        bus0(4'd4, 32'd40);
        bus1(4'd3, 32'd30);
        step();
        chk("R6 older at higher slot", disp_dst, 2);
        chk("R6 older value", disp_vj, 30);
        step();
        chk("R6 younger after", disp_dst, 5);
        step();
        chk("R6 drained", free_cnt, 3);
    endtask

    task automatic t_flush();
        issue(4'd7, 4'd6, 1'b1, 4'd2, 32'd0, 1'b0, 4'd0, 32'd0);
        step();
        issue(4'd7, 4'd7, 1'b1, 4'd3, 32'd0, 1'b0, 4'd0, 32'd0);
        step();
        chk("R9 two held", free_cnt, 1);
        flush = 1'b1;
        step();
        chk("R8 emptied", free_cnt, 3);
        bus0(4'd2, 32'd1);
        bus1(4'd3, 32'd1);
        step();
        chk("R8 no dispatch", disp_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_ready_issue();
        t_wake_one();
        t_dual_wake();
        t_issue_capture();
        t_fill_and_age();
        t_age_index();
        t_flush();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule